// File: doc/BRIEF.md
# Pipeline Hazard Stall Unit

This block decides, every cycle, whether the front of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back, one cycle each) may advance. The pipeline has no bypass network, so a value written by an older instruction can be read only once that instruction reaches write-back. The register file writes early in the cycle, so the decode stage can read the value in that same cycle. Any decode-stage source that names the pending destination of an instruction in the execute or memory stage must therefore wait. Memory has one port. An instruction in the memory stage that loads or stores takes that port, and instruction fetch must sit idle for the cycle.

The unit is purely combinational. It takes the decode stage's valid bit, two source register numbers and their in-use flags. From the execute and memory stages it takes the valid bit, the write-enable bit and the destination register number, and from the memory stage also a flag that the instruction accesses memory. First it sorts the cycle into one of four named modes, and each mode then maps to a fixed set of control outputs. FLOW is chosen when there is no hazard. DATA is chosen for a read-after-write dependency alone. PORT is chosen for a memory-port conflict alone. BOTH is chosen when the two coincide. A data stall freezes the program counter and the fetch/decode register and places a no-operation into execute. A port stall freezes only the program counter, while the decode instruction moves on and a no-operation enters decode. Write-after-read and write-after-write cases never stall, because all writes happen in order at the last stage, so destination fields of the decode instruction are not examined.

Top module: `hz_stall_unit`

## Requirements
- R1: With no hazard, all four outputs (`pc_hold`, `fd_hold`, `fd_bubble`, `dx_bubble`) are 0, so one instruction enters per cycle.
- R2: When decode is valid, source A is in use and non-zero, and the execute stage is valid, writing, and has destination equal to source A, the mode is DATA: `pc_hold`=1, `fd_hold`=1, `dx_bubble`=1 and `fd_bubble`=0.
- R3: A match of either source, A or B, against a valid, writing memory-stage destination gives the same DATA outputs as R2.
- R4: Register 0 never causes a data stall, even when an older stage writes register 0.
- R5: No data stall occurs when the producing stage is invalid or not writing, when the matching source is not in use, or when decode is invalid.
- R6: A dependent instruction right behind its producer stalls for exactly two cycles (producer in execute, then in memory) and proceeds when the producer is in write-back.
- R7: A valid memory-stage instruction with its access flag set, with no data hazard, gives PORT mode: `pc_hold`=1, `fd_bubble`=1, `fd_hold`=0 and `dx_bubble`=0. The access flag has no effect on an invalid memory stage.
- R8: When a data hazard and a port conflict coincide, the mode is BOTH: `pc_hold`=1, `fd_hold`=1, `dx_bubble`=1 and `fd_bubble`=0. Hold and bubble on the fetch/decode register are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_src_a | input | REG_AW | First source register number in decode |
| id_src_a_used | input | 1 | First source is read by the decode instruction |
| id_src_b | input | REG_AW | Second source register number in decode |
| id_src_b_used | input | 1 | Second source is read by the decode instruction |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | REG_AW | Execute-stage destination register |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_AW | Memory-stage destination register |
| mem_acc | input | 1 | Memory-stage instruction loads or stores |
| pc_hold | output | 1 | Keep the program counter unchanged |
| fd_hold | output | 1 | Keep the fetch/decode register unchanged |
| fd_bubble | output | 1 | Load a no-operation into the fetch/decode register |
| dx_bubble | output | 1 | Load a no-operation into the decode/execute register |

## Verification
The dependency check and the shared-port check can fire in the same cycle. A load or store in the memory stage that also writes a register the decode instruction reads triggers both. Case A is a load whose destination is decode's second source. Case B is a store that writes no register while the execute stage holds a matching producer. In both cases the bench expects the BOTH outputs, with the fetch/decode register held rather than bubbled. Separate cases apply each condition alone, so that a wrong priority between the two shows up as a mismatch in `fd_hold` or `fd_bubble`.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        MODE_FLOW = 2'd0,
        MODE_DATA = 2'd1,
        MODE_PORT = 2'd2,
        MODE_BOTH = 2'd3
    } hz_mode_e;

    typedef struct packed {
        logic pc_hold;
        logic fd_hold;
        logic fd_bubble;
        logic dx_bubble;
    } hz_ctl_t;

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
    parameter int AW   = 5,
    parameter int NDST = 2
) (
    input  logic [AW-1:0]      src,
    input  logic               src_used,
    input  logic [NDST*AW-1:0] dst_flat,
    input  logic [NDST-1:0]    dst_live,
    output logic               hit
);
    logic [NDST-1:0] per_dst;

    generate
        for (genvar k = 0; k < NDST; k++) begin : g_dst
            assign per_dst[k] = dst_live[k] && (dst_flat[k*AW +: AW] == src);
        end
    endgenerate

    // register zero is hard-wired and can never be pending
    assign hit = src_used && (src != '0) && (|per_dst);
endmodule

// File: rtl/hz_port_check.sv
module hz_port_check (
    input  logic mem_valid,
    input  logic mem_acc,
    output logic port_busy
);
    // a live load/store in stage four owns the single memory port
    assign port_busy = mem_valid & mem_acc;
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
(
    input  logic     dec_valid,
    input  logic     raw_hit,
    input  logic     port_busy,
    output hz_mode_e mode,
    output hz_ctl_t  ctl
);
    logic data_stall;

    assign data_stall = dec_valid & raw_hit;

    // mode selection
    always_comb begin
        unique case ({data_stall, port_busy})
            2'b00:   mode = MODE_FLOW;
            2'b10:   mode = MODE_DATA;
            2'b01:   mode = MODE_PORT;
            default: mode = MODE_BOTH;
        endcase
    end

    // per-mode controls
    always_comb begin
        ctl = '0;
        unique case (mode)
            MODE_FLOW: ctl = '0;
            MODE_DATA: begin
                ctl.pc_hold   = 1'b1;
                ctl.fd_hold   = 1'b1;
                ctl.dx_bubble = 1'b1;
            end
            MODE_PORT: begin
                ctl.pc_hold   = 1'b1;
                ctl.fd_bubble = 1'b1;
            end
            MODE_BOTH: begin
                ctl.pc_hold   = 1'b1;
                ctl.fd_hold   = 1'b1;
                ctl.dx_bubble = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic              id_src_a_used,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic              id_src_b_used,
    input  logic              ex_valid,
    input  logic              ex_wr,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              mem_valid,
    input  logic              mem_wr,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_acc,
    output logic              pc_hold,
    output logic              fd_hold,
    output logic              fd_bubble,
    output logic              dx_bubble
);
    localparam int NUM_SRC = 2;
    localparam int NUM_DST = 2;

    logic [NUM_SRC-1:0][REG_AW-1:0] src_vec;
    logic [NUM_SRC-1:0]             src_use;
    logic [NUM_SRC-1:0]             src_hit;
    logic [NUM_DST*REG_AW-1:0]      dst_flat;
    logic [NUM_DST-1:0]             dst_live;
    logic                           port_busy;
    hz_mode_e                       mode;
    hz_ctl_t                        ctl;

    assign src_vec  = {id_src_b, id_src_a};
    assign src_use  = {id_src_b_used, id_src_a_used};
    assign dst_flat = {mem_dst, ex_dst};
    assign dst_live = {mem_valid & mem_wr, ex_valid & ex_wr};

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            hz_src_match #(
                .AW   (REG_AW),
                .NDST (NUM_DST)
            ) u_match (
                .src      (src_vec[s]),
                .src_used (src_use[s]),
                .dst_flat (dst_flat),
                .dst_live (dst_live),
                .hit      (src_hit[s])
            );
        end
    endgenerate

    hz_port_check u_port (
        .mem_valid (mem_valid),
        .mem_acc   (mem_acc),
        .port_busy (port_busy)
    );

    hz_stall_ctrl u_ctrl (
        .dec_valid (id_valid),
        .raw_hit   (|src_hit),
        .port_busy (port_busy),
        .mode      (mode),
        .ctl       (ctl)
    );

    assign pc_hold   = ctl.pc_hold;
    assign fd_hold   = ctl.fd_hold;
    assign fd_bubble = ctl.fd_bubble;
    assign dx_bubble = ctl.dx_bubble;
endmodule

// File: rtl/hz_stall_unit_chk.sv
module hz_stall_unit_chk #(
    parameter int AW = 5
) (
    input logic          id_valid,
    input logic [AW-1:0] id_src_a,
    input logic          id_src_a_used,
    input logic [AW-1:0] id_src_b,
    input logic          id_src_b_used,
    input logic          ex_valid,
    input logic          ex_wr,
    input logic [AW-1:0] ex_dst,
    input logic          mem_valid,
    input logic          mem_wr,
    input logic [AW-1:0] mem_dst,
    input logic          mem_acc,
    input logic          pc_hold,
    input logic          fd_hold,
    input logic          fd_bubble,
    input logic          dx_bubble
);
    always_comb begin
        assert_fd_exclusive_R8: assert (!(fd_hold && fd_bubble))
            else $error("fetch/decode held and bubbled together");
        assert_dx_bubble_freezes_R2: assert (!dx_bubble || (pc_hold && fd_hold))
            else $error("execute bubble without front freeze");
        assert_port_blocks_fetch_R7: assert (!(mem_valid && mem_acc) || pc_hold)
            else $error("fetch not held during data access");
        assert_zero_reg_R4: assert (!((id_src_a == '0) && (id_src_b == '0)) || !dx_bubble)
            else $error("register zero produced a stall");
        assert_idle_flow_R1: assert (id_valid || (mem_valid && mem_acc) || !pc_hold)
            else $error("hold without any cause");
        assert_ex_raw_R2: assert (!(id_valid && id_src_a_used && (id_src_a != '0) &&
                                    ex_valid && ex_wr && (ex_dst == id_src_a)) || dx_bubble)
            else $error("missed execute-stage dependency");
        assert_mem_raw_R3: assert (!(id_valid && id_src_b_used && (id_src_b != '0) &&
                                     mem_valid && mem_wr && (mem_dst == id_src_b)) || dx_bubble)
            else $error("missed memory-stage dependency");
    end
endmodule

bind hz_stall_unit hz_stall_unit_chk #(.AW(REG_AW)) u_chk (
    .id_valid      (id_valid),
    .id_src_a      (id_src_a),
    .id_src_a_used (id_src_a_used),
    .id_src_b      (id_src_b),
    .id_src_b_used (id_src_b_used),
    .ex_valid      (ex_valid),
    .ex_wr         (ex_wr),
    .ex_dst        (ex_dst),
    .mem_valid     (mem_valid),
    .mem_wr        (mem_wr),
    .mem_dst       (mem_dst),
    .mem_acc       (mem_acc),
    .pc_hold       (pc_hold),
    .fd_hold       (fd_hold),
    .fd_bubble     (fd_bubble),
    .dx_bubble     (dx_bubble)
);

// File: tb/hz_stall_unit_tb.sv
module hz_stall_unit_tb;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 4 ns period

    logic          id_valid, id_src_a_used, id_src_b_used;
    logic [AW-1:0] id_src_a, id_src_b, ex_dst, mem_dst;
    logic          ex_valid, ex_wr, mem_valid, mem_wr, mem_acc;
    logic          pc_hold, fd_hold, fd_bubble, dx_bubble;

    hz_stall_unit #(.REG_AW(AW)) u_dut (
        .id_valid(id_valid), .id_src_a(id_src_a), .id_src_a_used(id_src_a_used),
        .id_src_b(id_src_b), .id_src_b_used(id_src_b_used),
        .ex_valid(ex_valid), .ex_wr(ex_wr), .ex_dst(ex_dst),
        .mem_valid(mem_valid), .mem_wr(mem_wr), .mem_dst(mem_dst), .mem_acc(mem_acc),
        .pc_hold(pc_hold), .fd_hold(fd_hold), .fd_bubble(fd_bubble), .dx_bubble(dx_bubble)
    );

    typedef struct {
        logic [3:0] ctl;   // {pc_hold, fd_hold, fd_bubble, dx_bubble}
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    task automatic drive(input logic dv, input logic [AW-1:0] sa, input logic ua,
                         input logic [AW-1:0] sb, input logic ub,
                         input logic xv, input logic xw, input logic [AW-1:0] xd,
                         input logic mv, input logic mw, input logic [AW-1:0] md,
                         input logic ma, input logic [3:0] want, input string tag);
        exp_t e;
        @(posedge clk);
        id_valid = dv; id_src_a = sa; id_src_a_used = ua;
        id_src_b = sb; id_src_b_used = ub;
        ex_valid = xv; ex_wr = xw; ex_dst = xd;
        mem_valid = mv; mem_wr = mw; mem_dst = md; mem_acc = ma;
        e.ctl = want;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare away from the driving edge
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            logic [3:0] got;
            e = exp_q.pop_front();
            got = {pc_hold, fd_hold, fd_bubble, dx_bubble};
            checks++;
            if (got !== e.ctl) begin
                failures++;
                $display("FAIL %s got=%b exp=%b", e.tag, got, e.ctl);
            end
        end
    end

    localparam logic [3:0] C_FLOW = 4'b0000;
    localparam logic [3:0] C_DATA = 4'b1101;
    localparam logic [3:0] C_PORT = 4'b1010;

    initial begin
        id_valid = 0; id_src_a = 0; id_src_a_used = 0; id_src_b = 0; id_src_b_used = 0;
        ex_valid = 0; ex_wr = 0; ex_dst = 0;
        mem_valid = 0; mem_wr = 0; mem_dst = 0; mem_acc = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: idle state and hazard-free flow
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, C_FLOW, "R1 idle");
        drive(1, 3, 1, 4, 1, 1, 1, 5, 1, 1, 6, 0, C_FLOW, "R1 no match");
        // R2: source A against execute destination
        drive(1, 7, 1, 4, 1, 1, 1, 7, 0, 0, 0, 0, C_DATA, "R2 ex raw");
        // R3: source B against memory destination, and source A against memory
        drive(1, 3, 1, 9, 1, 0, 0, 0, 1, 1, 9, 0, C_DATA, "R3 mem raw srcB");
        drive(1, 12, 1, 4, 0, 0, 0, 0, 1, 1, 12, 0, C_DATA, "R3 mem raw srcA");
        // R4: register zero
        drive(1, 0, 1, 0, 1, 1, 1, 0, 1, 1, 0, 0, C_FLOW, "R4 reg zero");
        // R5: qualifiers
        drive(1, 7, 1, 4, 1, 1, 0, 7, 0, 0, 0, 0, C_FLOW, "R5 producer not writing");
        drive(1, 7, 1, 4, 1, 0, 1, 7, 0, 0, 0, 0, C_FLOW, "R5 producer invalid");
        drive(1, 7, 0, 4, 1, 1, 1, 7, 0, 0, 0, 0, C_FLOW, "R5 source unused");
        drive(0, 7, 1, 4, 1, 1, 1, 7, 0, 0, 0, 0, C_FLOW, "R5 decode invalid");
        // R6: back-to-back dependency, producer moves ex -> mem -> write-back
        drive(1, 8, 1, 2, 1, 1, 1, 8, 0, 0, 0, 0, C_DATA, "R6 stall cycle 1");
        drive(1, 8, 1, 2, 1, 0, 0, 0, 1, 1, 8, 0, C_DATA, "R6 stall cycle 2");
        drive(1, 8, 1, 2, 1, 0, 0, 0, 0, 0, 0, 0, C_FLOW, "R6 released");
        // R7: port conflict alone, and access flag on an invalid stage
        drive(1, 3, 1, 4, 1, 0, 0, 0, 1, 1, 11, 1, C_PORT, "R7 port busy");
        drive(1, 3, 1, 4, 1, 0, 0, 0, 0, 0, 0, 1, C_FLOW, "R7 invalid mem ignored");
        // R8: both at once
        drive(1, 3, 1, 9, 1, 0, 0, 0, 1, 1, 9, 1, C_DATA, "R8 load feeds decode");
        drive(1, 6, 1, 4, 1, 1, 1, 6, 1, 0, 0, 1, C_DATA, "R8 ex raw plus store");

        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule